// File: doc/BRIEF.md
# Challenge-Response Authentication Sequencer

This block runs the tag side of a challenge-response exchange on a contactless link. A `start` pulse moves it out of standby. It then takes a serial frame one bit at a time, with each bit qualified by a valid strobe. The frame holds a random number, then a short run of padding bits that must all be zero, then the reader's cipher word. The random number is presented on a parallel output as soon as its last bit has arrived. The cipher functions are computed outside the block, so an external engine can use that output.

After the final bit, the received reader cipher is compared with the expected value on a parallel input. On a match with clean padding, the block sends a Manchester-coded header of twelve ones and four zeros, followed by the tag's response cipher. In any other case it sends only a fixed refusal pattern of half-bit levels. The transmit side moves one half-bit per pulse of a half-bit clock enable. When the last half-bit has been consumed, the block pulses `done` and returns to standby.

Top module: `auth_seq`

## Requirements
- R1: After reset, `tx_active`, `tx_out`, `rn_valid` and `done` are all 0.
- R2: The frame after `start` is RN_W random bits, then DIV_W padding bits, then F_W reader-cipher bits, each field MSB first. A bit is taken only in a cycle where `rx_valid` is 1, and any number of idle cycles may sit between bits.
- R3: `rn_valid` goes to 0 when a command starts. It goes to 1 once the RN_W-th bit has been taken, and from then `rn_out` holds the random number with the first received bit at bit RN_W-1.
- R4: If the reader cipher equals `exp_cipher` and every padding bit is 0, transmission begins with 12 Manchester ones and then 4 Manchester zeros. A one is sent as a high half-bit then a low half-bit; a zero is sent as low then high.
- R5: After that header, the G_W bits of `resp_cipher` are sent MSB first in the same Manchester code.
- R6: If the reader cipher differs from `exp_cipher` in any bit, only the NAK_W half-bit levels of NAK_PATTERN are sent, bit NAK_W-1 first, and no header is sent.
- R7: A 1 in any padding bit produces the NAK_PATTERN sequence of R6, even when the cipher matches.
- R8: While `tx_active` is 1, `tx_out` moves to the next half-bit only on a cycle with `half_en` high and holds its level otherwise. While `tx_active` is 0, `tx_out` is 0.
- R9: The cycle after the last half-bit is consumed, `tx_active` is 0 and `done` is 1 for exactly one cycle. The block is then in standby and accepts a new `start`.
- R10: `start` has no effect while a command is in progress. `rx_valid` has no effect in standby: it leaves `rn_valid` and `tx_active` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins a command when in standby |
| rx_bit | input | 1 | Serial receive data |
| rx_valid | input | 1 | Qualifies `rx_bit` for one cycle |
| exp_cipher | input | F_W | Expected reader cipher |
| resp_cipher | input | G_W | Tag response cipher to transmit |
| half_en | input | 1 | Half-bit clock enable for the transmitter |
| tx_out | output | 1 | Serial Manchester transmit level |
| tx_active | output | 1 | Transmission in progress |
| rn_out | output | RN_W | Received random number |
| rn_valid | output | 1 | `rn_out` is complete |
| done | output | 1 | One-cycle pulse at the end of a command |

## Verification
One matching frame is checked half-bit by half-bit against the header and response stream. Every bit of the reader cipher is then flipped on its own, one frame per flip, to show that each position reaches the comparison and produces the refusal pattern. Each padding bit is raised alone while the cipher is kept correct, to separate a padding failure from a cipher mismatch. Further frames add idle gaps with a toggling data line, stray strobes in standby, and a `start` pulse during transmission, to show that only qualified bits are taken and that a running command is not disturbed.

// File: rtl/auth_seq_pkg.sv
package auth_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RECV = 2'd1,
    ST_SEND = 2'd2
  } seq_state_e;

  // Manchester level for one half of a bit: first half carries the bit,
  // second half its inverse.
  function automatic logic manch_level(input logic bit_v, input logic second_half);
    return second_half ? ~bit_v : bit_v;
  endfunction

  // Header bit value at a given bit position (ones first, then zeros).
  function automatic logic header_bit(input int pos, input int n_ones);
    return (pos < n_ones) ? 1'b1 : 1'b0;
  endfunction

endpackage

// File: rtl/auth_seq_rx.sv
module auth_seq_rx #(
  parameter int RN_W  = 56,
  parameter int DIV_W = 7,
  parameter int F_W   = 28
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            arm,
  input  logic            en,
  input  logic            rx_bit,
  input  logic            rx_valid,
  output logic [RN_W-1:0] rn_q,
  output logic            rn_full,
  output logic            div_err,
  output logic [F_W-1:0]  f_q,
  output logic            frame_end
);

  localparam int TOT = RN_W + DIV_W + F_W;
  localparam int CW  = $clog2(TOT + 1);
  localparam logic [CW-1:0] CNT_RN_LAST  = CW'(RN_W - 1);
  localparam logic [CW-1:0] CNT_DIV_BEG  = CW'(RN_W);
  localparam logic [CW-1:0] CNT_F_BEG    = CW'(RN_W + DIV_W);
  localparam logic [CW-1:0] CNT_LAST     = CW'(TOT - 1);
  localparam logic [CW-1:0] CNT_FULL     = CW'(TOT);

  logic [CW-1:0] cnt;
  logic          take;
  logic          in_rn;
  logic          in_div;

  assign take   = en && rx_valid && (cnt != CNT_FULL);
  assign in_rn  = (cnt < CNT_DIV_BEG);
  assign in_div = (cnt >= CNT_DIV_BEG) && (cnt < CNT_F_BEG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      rn_q      <= '0;
      rn_full   <= 1'b0;
      div_err   <= 1'b0;
      f_q       <= '0;
      frame_end <= 1'b0;
    end else if (arm) begin
      cnt       <= '0;
      rn_full   <= 1'b0;
      div_err   <= 1'b0;
      frame_end <= 1'b0;
    end else begin
      frame_end <= 1'b0;
      if (take) begin
        if (in_rn) begin
          rn_q <= {rn_q[RN_W-2:0], rx_bit};
        end else if (in_div) begin
          div_err <= div_err | rx_bit;
        end else begin
          f_q <= {f_q[F_W-2:0], rx_bit};
        end
        if (cnt == CNT_RN_LAST) rn_full <= 1'b1;
        if (cnt == CNT_LAST) frame_end <= 1'b1;
        cnt <= cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/auth_seq_tx.sv
module auth_seq_tx
  import auth_seq_pkg::*;
#(
  parameter int               G_W         = 20,
  parameter int               HDR_ONES    = 12,
  parameter int               HDR_ZEROS   = 4,
  parameter int               NAK_W       = 8,
  parameter logic [NAK_W-1:0] NAK_PATTERN = 8'b1010_1100
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic           load_pass,
  input  logic [G_W-1:0] g_in,
  input  logic           half_en,
  output logic           tx_out,
  output logic           tx_active,
  output logic           fin
);

  localparam int HB_OK  = 2 * (HDR_ONES + HDR_ZEROS + G_W);
  localparam int HB_NAK = NAK_W;
  localparam int HB_MAX = (HB_OK > HB_NAK) ? HB_OK : HB_NAK;
  localparam int IW     = (HB_MAX > 2) ? $clog2(HB_MAX) : 1;
  localparam logic [IW-1:0] LAST_OK  = IW'(HB_OK - 1);
  localparam logic [IW-1:0] LAST_NAK = IW'(HB_NAK - 1);

  logic           pass_r;
  logic [G_W-1:0] g_r;
  logic [IW-1:0]  idx;
  logic [IW-1:0]  last_idx;
  logic           ok_lvl;
  logic           nak_lvl;
  logic           step;

  function automatic logic ok_level(input int hb, input logic [G_W-1:0] g);
    int             pos;
    int             k;
    logic           bv;
    logic [G_W-1:0] sh;
    pos = hb / 2;
    if (pos < HDR_ONES + HDR_ZEROS) begin
      bv = header_bit(pos, HDR_ONES);
    end else begin
      k  = pos - HDR_ONES - HDR_ZEROS;
      sh = g << k;
      bv = sh[G_W-1];
    end
    return manch_level(bv, hb[0]);
  endfunction

  function automatic logic nak_level(input int hb);
    logic [NAK_W-1:0] sh;
    sh = NAK_PATTERN << hb;
    return sh[NAK_W-1];
  endfunction

  assign last_idx = pass_r ? LAST_OK : LAST_NAK;
  assign ok_lvl   = ok_level(int'(idx), g_r);
  assign nak_lvl  = nak_level(int'(idx));
  assign tx_out   = tx_active && (pass_r ? ok_lvl : nak_lvl);
  assign step     = tx_active && half_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_active <= 1'b0;
      pass_r    <= 1'b0;
      g_r       <= '0;
      idx       <= '0;
      fin       <= 1'b0;
    end else if (load) begin
      tx_active <= 1'b1;
      pass_r    <= load_pass;
      g_r       <= g_in;
      idx       <= '0;
      fin       <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (step) begin
        if (idx == last_idx) begin
          tx_active <= 1'b0;
          fin       <= 1'b1;
          idx       <= '0;
        end else begin
          idx <= idx + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/auth_seq.sv
module auth_seq
  import auth_seq_pkg::*;
#(
  parameter int               RN_W        = 56,
  parameter int               DIV_W       = 7,
  parameter int               F_W         = 28,
  parameter int               G_W         = 20,
  parameter int               HDR_ONES    = 12,
  parameter int               HDR_ZEROS   = 4,
  parameter int               NAK_W       = 8,
  parameter logic [NAK_W-1:0] NAK_PATTERN = 8'b1010_1100
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            rx_bit,
  input  logic            rx_valid,
  input  logic [F_W-1:0]  exp_cipher,
  input  logic [G_W-1:0]  resp_cipher,
  input  logic            half_en,
  output logic            tx_out,
  output logic            tx_active,
  output logic [RN_W-1:0] rn_out,
  output logic            rn_valid,
  output logic            done
);

  seq_state_e     state;
  logic           arm;
  logic           rx_en;
  logic           frame_end;
  logic           div_err;
  logic [F_W-1:0] f_q;
  logic           pass_now;
  logic           pass_q;
  logic           tx_load;
  logic           tx_fin;
  logic           busy;

  assign busy     = (state != ST_IDLE);
  assign arm      = (state == ST_IDLE) && start;
  assign rx_en    = (state == ST_RECV);
  assign pass_now = !div_err && (f_q == exp_cipher);
  assign tx_load  = (state == ST_RECV) && frame_end;
  assign done     = tx_fin;

  auth_seq_rx #(
    .RN_W (RN_W),
    .DIV_W(DIV_W),
    .F_W  (F_W)
  ) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .arm      (arm),
    .en       (rx_en),
    .rx_bit   (rx_bit),
    .rx_valid (rx_valid),
    .rn_q     (rn_out),
    .rn_full  (rn_valid),
    .div_err  (div_err),
    .f_q      (f_q),
    .frame_end(frame_end)
  );

  auth_seq_tx #(
    .G_W        (G_W),
    .HDR_ONES   (HDR_ONES),
    .HDR_ZEROS  (HDR_ZEROS),
    .NAK_W      (NAK_W),
    .NAK_PATTERN(NAK_PATTERN)
  ) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tx_load),
    .load_pass(pass_now),
    .g_in     (resp_cipher),
    .half_en  (half_en),
    .tx_out   (tx_out),
    .tx_active(tx_active),
    .fin      (tx_fin)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      pass_q <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (start) state <= ST_RECV;
        ST_RECV: if (frame_end) begin
          state  <= ST_SEND;
          pass_q <= pass_now;
        end
        ST_SEND: if (tx_fin) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/auth_seq_chk.sv
module auth_seq_chk #(
  parameter int               NAK_W       = 8,
  parameter logic [NAK_W-1:0] NAK_PATTERN = 8'b1010_1100
) (
  input logic clk,
  input logic rst_n,
  input logic half_en,
  input logic tx_active,
  input logic tx_out,
  input logic done,
  input logic rn_valid,
  input logic busy,
  input logic pass_q
);

  // R8: line idles low
  p_idle_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_active |-> !tx_out);

  // R8: level holds between half-bit enables
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_active && $past(tx_active) && !$past(half_en)) |-> $stable(tx_out));

  // R9: done is a single-cycle pulse coinciding with end of transmission
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_active) |-> done);

  // R3: transmission only follows a complete random number
  p_rn_before_tx_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_active) |-> rn_valid);

  // R4: a passing command opens with the high half of a one
  p_hdr_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(tx_active) && pass_q) |-> tx_out);

  // R6: a failing command opens with the first refusal level
  p_nak_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(tx_active) && !pass_q) |-> (tx_out == NAK_PATTERN[NAK_W-1]));

  // R10: no transmission in standby
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !tx_active);

endmodule

bind auth_seq auth_seq_chk #(
  .NAK_W      (NAK_W),
  .NAK_PATTERN(NAK_PATTERN)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .half_en  (half_en),
  .tx_active(tx_active),
  .tx_out   (tx_out),
  .done     (done),
  .rn_valid (rn_valid),
  .busy     (busy),
  .pass_q   (pass_q)
);

// File: tb/auth_seq_tb.sv
module auth_seq_tb;

  localparam int RN_W = 56, DIV_W = 7, F_W = 28, G_W = 20;
  localparam logic [7:0] NAKP = 8'b1010_1100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, rx_bit = 1'b0, rx_valid = 1'b0, half_en = 1'b0;
  logic [F_W-1:0] exp_cipher = 28'hA5C31E7;
  logic [G_W-1:0] resp_cipher = 20'h93B6C;
  logic tx_out, tx_active, rn_valid, done;
  logic [RN_W-1:0] rn_out;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  auth_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .rx_bit(rx_bit), .rx_valid(rx_valid),
    .exp_cipher(exp_cipher), .resp_cipher(resp_cipher), .half_en(half_en),
    .tx_out(tx_out), .tx_active(tx_active), .rn_out(rn_out), .rn_valid(rn_valid),
    .done(done)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic exp_level(input bit pass, input int k);
    int b;
    logic v;
    if (!pass) return NAKP[7-k];
    b = k / 2;
    if (b < 12) v = 1'b1;
    else if (b < 16) v = 1'b0;
    else v = resp_cipher[G_W-1-(b-16)];
    return (k % 2 == 1) ? ~v : v;
  endfunction

  task automatic send_frame(input logic [RN_W-1:0] rn, input logic [DIV_W-1:0] dv,
                            input logic [F_W-1:0] f, input int gap);
    logic [RN_W+DIV_W+F_W-1:0] fr;
    fr = {rn, dv, f};
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk("R3 rn_valid cleared at start", 64'(rn_valid), 64'd0);
    for (int i = RN_W + DIV_W + F_W - 1; i >= 0; i--) begin
      rx_bit = fr[i]; rx_valid = 1'b1;
      @(negedge clk) rx_valid = 1'b0;
      for (int g = 0; g < gap; g++) begin
        rx_bit = ~rx_bit;
        @(negedge clk);
      end
    end
    @(negedge clk);
  endtask

  task automatic run_tx(input bit pass, input string req, input bit poke_start);
    int n;
    n = pass ? 2 * (16 + G_W) : 8;
    for (int k = 0; k < n; k++) begin
      chk(req, {62'd0, tx_active, tx_out}, {62'd0, 1'b1, exp_level(pass, k)});
      if (poke_start && k == 5) start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk("R8 hold without enable", 64'(tx_out), 64'(exp_level(pass, k)));
      half_en = 1'b1;
      @(negedge clk) half_en = 1'b0;
    end
    chk("R9 tx_active low at end", 64'(tx_active), 64'd0);
    chk("R9 done pulse", 64'(done), 64'd1);
    @(negedge clk);
    chk("R9 done single cycle", 64'(done), 64'd0);
    chk("R8 idle low", 64'(tx_out), 64'd0);
  endtask

  initial begin
    logic [RN_W-1:0] rn;
    repeat (3) @(negedge clk);
    chk("R1 tx_active", 64'(tx_active), 64'd0);
    chk("R1 tx_out", 64'(tx_out), 64'd0);
    chk("R1 rn_valid", 64'(rn_valid), 64'd0);
    chk("R1 done", 64'(done), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R4 R5 R3: matching frame
    rn = 56'hC0FFEE_1234_5678;
    send_frame(rn, '0, exp_cipher, 0);
    chk("R3 rn_out", 64'(rn_out), 64'(rn));
    chk("R3 rn_valid", 64'(rn_valid), 64'd1);
    run_tx(1'b1, "R4 R5 pass stream", 1'b0);

    // R10: stray strobes in standby
    for (int i = 0; i < 10; i++) begin
      rx_bit = i[0]; rx_valid = 1'b1;
      @(negedge clk) rx_valid = 1'b0;
    end
    chk("R10 no tx in standby", 64'(tx_active), 64'd0);
    chk("R10 rn_valid unchanged", 64'(rn_valid), 64'd1);

    // R2 with gaps, R10 start during tx, new cipher
    resp_cipher = 20'h5A0F3;
    rn = 56'h0F1E2D3C4B5A69;
    send_frame(rn, '0, exp_cipher, 2);
    chk("R2 R3 rn_out with gaps", 64'(rn_out), 64'(rn));
    run_tx(1'b1, "R2 R5 R10 pass after gaps", 1'b1);

    // R6: every single cipher bit flip
    for (int b = 0; b < F_W; b++) begin
      send_frame(56'(b) * 56'h1_0001, '0, exp_cipher ^ (28'd1 << b), 0);
      run_tx(1'b0, "R6 nak on mismatch", 1'b0);
    end

    // R7: every single padding bit set
    for (int b = 0; b < DIV_W; b++) begin
      send_frame(56'hABCDEF, 7'(1 << b), exp_cipher, 0);
      run_tx(1'b0, "R7 nak on padding", 1'b0);
    end

    // R9: standby again, good frame still accepted
    send_frame(56'h1, '0, exp_cipher, 1);
    run_tx(1'b1, "R9 pass after naks", 1'b0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule